// File: doc/BRIEF.md
# Three-bit-coded 32-bit arithmetic-logic unit

This block is the arithmetic-logic unit of a simple single-issue integer datapath. It is purely combinational. A 3-bit operation code selects one of five functions on two 32-bit operands: bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. It drives a 32-bit result and a flag that is high when that result is all zeros.

The surrounding datapath uses addition to form load and store effective addresses. It uses subtraction both for plain subtract and for the branch-if-equal test, and reads the zero flag as the "operands are equal" indicator. One shared adder serves add, subtract and the comparison. A generate parameter chooses between an explicit ripple-carry chain and a behavioural adder.

Top module: `alu32`

## Requirements
- R1: Operation code 3'b000 drives the result with the bitwise AND of `a_in` and `b_in`.
- R2: Operation code 3'b001 drives the result with the bitwise OR of `a_in` and `b_in`.
- R3: Operation code 3'b010 drives the result with `a_in + b_in` modulo 2^32. A carry out of bit 31 is dropped and not signalled.
- R4: Operation code 3'b110 drives the result with `a_in - b_in` modulo 2^32, with no overflow indication.
- R5: Operation code 3'b111 treats both operands as signed two's-complement values. The result is 32'h0000_0001 when `a_in` is less than `b_in` and 32'h0000_0000 otherwise. This holds even where the difference overflows 32 bits.
- R6: The unused operation codes 3'b011, 3'b100 and 3'b101 drive a result of 32'h0000_0000, whatever the operands.
- R7: `zero_flag` is 1 exactly when all 32 result bits are 0, for every operation code, including the unused ones.
- R8: The block holds no state. Result and flag depend only on the present inputs and settle within the same evaluation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 32 | First operand (minuend for subtract, left side of compare) |
| b_in | input | 32 | Second operand |
| op_sel | input | 3 | Operation code |
| result | output | 32 | Selected function of the operands |
| zero_flag | output | 1 | High when `result` is all zeros |

## Verification
The zero flag and the arithmetic result are produced together in one evaluation. A subtract of equal operands must therefore show both a zero difference and a raised flag at the same time. The bench provokes this with directed equal-operand subtracts and additions that wrap to zero. Its random stimulus also forces equal operands on a share of the vectors. Each vector is judged by comparing the result and the flag against a bench model. A second overlap is the signed compare near the overflow boundary. There the sign of the shared difference and the true ordering disagree, and directed extreme operands check that the compare follows the true ordering.

// File: rtl/alu32_pkg.sv
`timescale 1ns/1ps
package alu32_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 3'b000,
        OP_OR   = 3'b001,
        OP_ADD  = 3'b010,
        OP_RSV3 = 3'b011,
        OP_RSV4 = 3'b100,
        OP_RSV5 = 3'b101,
        OP_SUB  = 3'b110,
        OP_SLT  = 3'b111
    } alu_op_e;

endpackage

// File: rtl/alu32_addsub.sv
`timescale 1ns/1ps
// Shared adder/subtractor. Subtraction inverts b and injects a carry-in.
module alu32_addsub #(
    parameter int WIDTH  = 32,
    parameter bit RIPPLE = 1'b0
) (
    input  logic [WIDTH-1:0] a_val,
    input  logic [WIDTH-1:0] b_val,
    input  logic             do_sub,
    output logic [WIDTH-1:0] sum_val
);

    logic [WIDTH-1:0] b_eff;

    assign b_eff = b_val ^ {WIDTH{do_sub}};

    generate
        if (RIPPLE) begin : g_ripple
            logic [WIDTH-1:0] carry;
            assign carry[0] = do_sub;
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                assign sum_val[i] = a_val[i] ^ b_eff[i] ^ carry[i];
                if (i < WIDTH-1) begin : g_carry
                    assign carry[i+1] = (a_val[i] & b_eff[i])
                                      | (a_val[i] & carry[i])
                                      | (b_eff[i] & carry[i]);
                end
            end
        end else begin : g_behav
            assign sum_val = a_val + b_eff + {{(WIDTH-1){1'b0}}, do_sub};
        end
    endgenerate

endmodule

// File: rtl/alu32_less.sv
`timescale 1ns/1ps
// Signed ordering from sign bits: when signs differ, the negative operand
// is the smaller; when they match, the difference cannot overflow.
module alu32_less (
    input  logic a_sign,
    input  logic b_sign,
    input  logic diff_sign,
    output logic is_less
);

    always_comb begin
        if (a_sign != b_sign) begin
            is_less = a_sign;
        end else begin
            is_less = diff_sign;
        end
    end

endmodule

// File: rtl/alu32_zero.sv
`timescale 1ns/1ps
module alu32_zero #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] word,
    output logic             all_zero
);

    assign all_zero = ~|word;

endmodule

// File: rtl/alu32.sv
`timescale 1ns/1ps
module alu32 #(
    parameter int WIDTH  = 32,
    parameter bit RIPPLE = 1'b0
) (
    input  logic [WIDTH-1:0]          a_in,
    input  logic [WIDTH-1:0]          b_in,
    input  logic [alu32_pkg::OP_W-1:0] op_sel,
    output logic [WIDTH-1:0]          result,
    output logic                      zero_flag
);

    import alu32_pkg::*;

    localparam int MSB = WIDTH - 1;

    alu_op_e          op_code;
    logic             use_sub;
    logic [WIDTH-1:0] arith;
    logic             less;

    assign op_code = alu_op_e'(op_sel);
    assign use_sub = (op_code == OP_SUB) || (op_code == OP_SLT);

    alu32_addsub #(
        .WIDTH  (WIDTH),
        .RIPPLE (RIPPLE)
    ) u_addsub (
        .a_val   (a_in),
        .b_val   (b_in),
        .do_sub  (use_sub),
        .sum_val (arith)
    );

    alu32_less u_less (
        .a_sign    (a_in[MSB]),
        .b_sign    (b_in[MSB]),
        .diff_sign (arith[MSB]),
        .is_less   (less)
    );

    always_comb begin
        unique case (op_code)
            OP_AND:  result = a_in & b_in;
            OP_OR:   result = a_in | b_in;
            OP_ADD:  result = arith;
            OP_SUB:  result = arith;
            OP_SLT:  result = {{(WIDTH-1){1'b0}}, less};
            OP_RSV3: result = '0;
            OP_RSV4: result = '0;
            OP_RSV5: result = '0;
            default: result = '0;
        endcase
    end

    alu32_zero #(
        .WIDTH (WIDTH)
    ) u_zero (
        .word     (result),
        .all_zero (zero_flag)
    );

endmodule

// File: rtl/alu32_checker.sv
`timescale 1ns/1ps
module alu32_checker #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [2:0]       op_sel,
    input logic [WIDTH-1:0] result,
    input logic             zero_flag
);

    always_comb begin
        if (op_sel == 3'b000) begin
            p_and_r1: assert (result == (a_in & b_in)) else $error("R1 AND mismatch");
        end
        if (op_sel == 3'b001) begin
            p_or_r2: assert (result == (a_in | b_in)) else $error("R2 OR mismatch");
        end
        if (op_sel == 3'b010) begin
            p_add_r3: assert (result == WIDTH'(a_in + b_in)) else $error("R3 add mismatch");
        end
        if (op_sel == 3'b110) begin
            p_sub_r4: assert (result == WIDTH'(a_in - b_in)) else $error("R4 sub mismatch");
        end
        if (op_sel == 3'b111) begin
            p_slt_r5: assert ((result[WIDTH-1:1] == '0)
                && (result[0] == ($signed(a_in) < $signed(b_in))))
                else $error("R5 compare mismatch");
        end
        if (op_sel == 3'b011 || op_sel == 3'b100 || op_sel == 3'b101) begin
            p_rsv_r6: assert (result == '0) else $error("R6 unused code not zero");
        end
        p_zero_r7: assert (zero_flag == (result == '0)) else $error("R7 zero flag wrong");
    end

endmodule

bind alu32 alu32_checker #(.WIDTH(WIDTH)) u_alu32_checker (
    .a_in      (a_in),
    .b_in      (b_in),
    .op_sel    (op_sel),
    .result    (result),
    .zero_flag (zero_flag)
);

// File: tb/test_alu32.sv
`timescale 1ns/1ps
module test_alu32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a_in = '0;
    logic [31:0] b_in = '0;
    logic [2:0]  op_sel = '0;
    logic [31:0] result;
    logic        zero_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    alu32 i_alu32 (
        .a_in      (a_in),
        .b_in      (b_in),
        .op_sel    (op_sel),
        .result    (result),
        .zero_flag (zero_flag)
    );

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [2:0] op);
        case (op)
            3'b000:  return a & b;
            3'b001:  return a | b;
            3'b010:  return a + b;
            3'b110:  return a - b;
            3'b111:  return {31'b0, ($signed(a) < $signed(b))};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b110:  return "R4";
            3'b111:  return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op,
                         input string tag);
        logic [31:0] exp_r;
        logic        exp_z;
        @(posedge clk);
        a_in   = a;
        b_in   = b;
        op_sel = op;
        exp_r  = model(a, b, op);
        exp_z  = (exp_r == 32'h0);
        @(negedge clk);
        n_checks++;
        if (result !== exp_r) begin
            n_fail++;
            $display("FAIL %s op=%b a=%h b=%h result actual=%h expected=%h",
                     tag, op, a, b, result, exp_r);
        end
        n_checks++;
        if (zero_flag !== exp_z) begin
            n_fail++;
            $display("FAIL R7 (%s) op=%b a=%h b=%h zero actual=%b expected=%b",
                     tag, op, a, b, zero_flag, exp_z);
        end
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17_C0DE));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // reset state: all-zero inputs give AND of zeros, flag raised (R1, R7)
        @(negedge clk);
        n_checks++;
        if (result !== 32'h0 || zero_flag !== 1'b1) begin
            n_fail++;
            $display("FAIL R7 reset result=%h zero=%b expected=00000000 1", result, zero_flag);
        end

        // directed corners
        apply(32'hF0F0_1234, 32'h0FF0_FFFF, 3'b000, "R1");
        apply(32'hF0F0_0000, 32'h0F0F_0000, 3'b000, "R1");
        apply(32'hA000_0005, 32'h0500_0A00, 3'b001, "R2");
        apply(32'hFFFF_FFFF, 32'h0000_0001, 3'b010, "R3");      // wraps to zero, flag up
        apply(32'h7FFF_FFFF, 32'h0000_0001, 3'b010, "R3");
        apply(32'h1000_0000, 32'hFFFF_FFFC, 3'b010, "R3");      // negative offset address
        apply(32'h1234_5678, 32'h1234_5678, 3'b110, "R4");      // equality: zero result and flag
        apply(32'h0000_0000, 32'h0000_0001, 3'b110, "R4");
        apply(32'h8000_0000, 32'h0000_0001, 3'b111, "R5");      // diff overflows, still less
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111, "R5");      // diff overflows, not less
        apply(32'hFFFF_FFFF, 32'h0000_0000, 3'b111, "R5");
        apply(32'h0000_0005, 32'h0000_0005, 3'b111, "R5");
        apply(32'h8000_0000, 32'h7FFF_FFFF, 3'b111, "R5");
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011, "R6");
        apply(32'hFFFF_FFFF, 32'h1234_5678, 3'b100, "R6");
        apply(32'h8000_0001, 32'hFFFF_FFFF, 3'b101, "R6");

        // constrained random, every code, a share with equal operands (R8: settles same evaluation)
        for (int k = 0; k < 600; k++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            logic [2:0]  rop;
            ra  = $urandom;
            rb  = ($urandom_range(0, 3) == 0) ? ra : $urandom;
            if ($urandom_range(0, 7) == 0) ra = {ra[31], 31'h0};
            rop = 3'($urandom_range(0, 7));
            apply(ra, rb, rop, {req_of(rop), "/R8"});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule